// File: doc/BRIEF.md
# Multi-Word Register Loader

This block carries out a block load of consecutive 32-bit words into the upper part of a general register file. A single start pulse supplies a first register number and a byte address, which has already been formed as the base register value (or zero) plus the sign-extended 16-bit displacement. The block then issues one read per register. It covers every register from the first one up to and including the highest register (31 by default). Each returned word is written into the register file with its upper half cleared.

The read port is a simple request/ready pair. The block holds `rd_req_o` and `rd_addr_o` until the memory raises `rd_ready_i`. The memory then presents the word on `rd_data_i` in the cycle after acceptance. After each word, the address advances by 4 bytes and the register number advances by one.

The controller has four states:
- IDLE waits for `start_i`; the transition IDLE→REQ captures the first register and the address.
- REQ drives the read; the transition REQ→WAIT happens on acceptance.
- WAIT writes the returned word. It takes WAIT→REQ while registers remain and WAIT→DONE after the highest register.
- DONE raises the completion pulse and always returns DONE→IDLE.

Top module: `multi_word_loader`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rd_req_o`, `rf_we_o` and `done_o` are all 0.
- R2: A `start_i` sampled in IDLE makes `rd_req_o` rise on the next cycle, with `rd_addr_o` equal to the `start_addr_i` sampled with the start.
- R3: While `rd_req_o` is high and `rd_ready_i` is low, the request stays high in the next cycle with an unchanged `rd_addr_o`.
- R4: The cycle after a request is accepted (`rd_req_o` and `rd_ready_i` both high at a clock edge), `rf_we_o` is high for exactly that cycle. `rf_data_o` then equals `rd_data_i` in bits 31:0 and zero in bits 63:32.
- R5: Each request after the first in an operation addresses 4 bytes above the previous accepted one, wrapping modulo 2^64. Its write targets the register numbered one above the previous write.
- R6: An operation starting at register F writes registers F, F+1, … 31 in increasing order, which is exactly 32−F writes. It touches no other register and issues no request after the write to register 31.
- R7: A start with first register 31 performs a single read and a single write.
- R8: `done_o` is high for exactly one cycle, the cycle immediately after the write to register 31.
- R9: `start_i` is ignored in REQ, WAIT and DONE. It neither restarts nor alters the running operation, and it starts no new one after DONE.
- R10: `rd_req_o` and `rf_we_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (honoured only in IDLE) |
| first_reg_i | input | 5 | Register number of the first destination |
| start_addr_i | input | 64 | Byte address of the first word |
| rd_req_o | output | 1 | Read request, held until accepted |
| rd_addr_o | output | 64 | Byte address of the current read |
| rd_ready_i | input | 1 | Memory accepts the request this cycle |
| rd_data_i | input | 32 | Returned word, valid the cycle after acceptance |
| rf_we_o | output | 1 | Register file write enable |
| rf_idx_o | output | 5 | Register file write index |
| rf_data_o | output | 64 | Zero-extended word to write |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A corrupted state register shows within one cycle. It appears as a request and a write in the same cycle, a write with no accepted read before it, or a done pulse that does not follow the write to register 31. A wrong register or address counter is hidden until the next request or write. At that point `rd_addr_o` is off from the previous accepted address plus 4, or `rf_idx_o` skips or repeats a number. The write count for the operation then differs from 32 minus the first register. The reference model compares every port on every cycle while the ready input is driven by three patterns: always ready, pseudo-random, and long stalls. Start pulses are injected mid-operation and in the DONE cycle.

// File: rtl/mwl_pkg.sv
package mwl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } mwl_state_e;

endpackage

// File: rtl/mwl_fsm.sv
module mwl_fsm
    import mwl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic mem_ready_i,
    input  logic at_last_i,
    output logic load_o,
    output logic step_o,
    output logic req_o,
    output logic we_o,
    output logic done_o
);

    mwl_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)     state_d = ST_REQ;
            ST_REQ:  if (mem_ready_i) state_d = ST_WAIT;
            ST_WAIT: state_d = at_last_i ? ST_DONE : ST_REQ;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // output decode
    always_comb begin
        load_o = 1'b0;
        step_o = 1'b0;
        req_o  = 1'b0;
        we_o   = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE: load_o = start_i;
            ST_REQ:  req_o  = 1'b1;
            ST_WAIT: begin
                we_o   = 1'b1;
                step_o = !at_last_i;
            end
            ST_DONE: done_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/mwl_cursor.sv
module mwl_cursor #(
    parameter int ADDR_W     = 64,
    parameter int IDX_W      = 5,
    parameter int STEP_BYTES = 4,
    parameter int LAST_IDX   = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [IDX_W-1:0]  first_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              at_last_o
);

    localparam logic [IDX_W-1:0]  LastIdx = IDX_W'(LAST_IDX);
    localparam logic [ADDR_W-1:0] Stride  = ADDR_W'(STEP_BYTES);

    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            addr_q <= '0;
        end else if (load_i) begin
            idx_q  <= first_i;
            addr_q <= base_i;
        end else if (step_i) begin
            idx_q  <= idx_q + 1'b1;
            addr_q <= addr_q + Stride;
        end
    end

    assign idx_o     = idx_q;
    assign addr_o    = addr_q;
    assign at_last_o = (idx_q == LastIdx);

endmodule

// File: rtl/mwl_zext.sv
module mwl_zext #(
    parameter int WORD_W = 32,
    parameter int REG_W  = 64
) (
    input  logic [WORD_W-1:0] word_i,
    output logic [REG_W-1:0]  reg_o
);

    generate
        if (REG_W > WORD_W) begin : g_pad
            assign reg_o = {{(REG_W-WORD_W){1'b0}}, word_i};
        end else begin : g_same
            assign reg_o = word_i;
        end
    endgenerate

endmodule

// File: rtl/multi_word_loader.sv
module multi_word_loader #(
    parameter  int NUM_REGS = 32,
    parameter  int ADDR_W   = 64,
    parameter  int WORD_W   = 32,
    parameter  int REG_W    = 64,
    localparam int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [IDX_W-1:0]  first_reg_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ready_i,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic              rf_we_o,
    output logic [IDX_W-1:0]  rf_idx_o,
    output logic [REG_W-1:0]  rf_data_o,
    output logic              done_o
);

    localparam int StepBytes = WORD_W / 8;
    localparam int LastIdx   = NUM_REGS - 1;

    logic load, step, at_last;

    mwl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .mem_ready_i (rd_ready_i),
        .at_last_i   (at_last),
        .load_o      (load),
        .step_o      (step),
        .req_o       (rd_req_o),
        .we_o        (rf_we_o),
        .done_o      (done_o)
    );

    mwl_cursor #(
        .ADDR_W     (ADDR_W),
        .IDX_W      (IDX_W),
        .STEP_BYTES (StepBytes),
        .LAST_IDX   (LastIdx)
    ) u_cursor (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .step_i    (step),
        .first_i   (first_reg_i),
        .base_i    (start_addr_i),
        .idx_o     (rf_idx_o),
        .addr_o    (rd_addr_o),
        .at_last_o (at_last)
    );

    mwl_zext #(
        .WORD_W (WORD_W),
        .REG_W  (REG_W)
    ) u_zext (
        .word_i (rd_data_i),
        .reg_o  (rf_data_o)
    );

endmodule

// File: rtl/mwl_checker.sv
module mwl_checker #(
    parameter int ADDR_W   = 64,
    parameter int WORD_W   = 32,
    parameter int REG_W    = 64,
    parameter int IDX_W    = 5,
    parameter int LAST_IDX = 31
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req_o,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              rd_ready_i,
    input logic [WORD_W-1:0] rd_data_i,
    input logic              rf_we_o,
    input logic [IDX_W-1:0]  rf_idx_o,
    input logic [REG_W-1:0]  rf_data_o,
    input logic              done_o
);

    localparam logic [IDX_W-1:0]  LastI = IDX_W'(LAST_IDX);
    localparam logic [ADDR_W-1:0] Step  = ADDR_W'(WORD_W / 8);

    logic [ADDR_W-1:0] last_acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       last_acc_q <= '0;
        else if (rd_req_o && rd_ready_i)  last_acc_q <= rd_addr_o;
    end

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ready_i) |=> (rd_req_o && $stable(rd_addr_o)));

    // R4
    write_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && rd_ready_i) |=> (rf_we_o &&
            rf_data_o == REG_W'(rd_data_i)));

    // R5
    next_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_o && rf_idx_o != LastI) |=> (rd_req_o && rd_addr_o == last_acc_q + Step));

    // R6
    stop_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_o && rf_idx_o == LastI) |=> (!rd_req_o && !rf_we_o));

    // R8
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_o && rf_idx_o == LastI) |=> done_o);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    req_write_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req_o && rf_we_o));

endmodule

bind multi_word_loader mwl_checker #(
    .ADDR_W   (ADDR_W),
    .WORD_W   (WORD_W),
    .REG_W    (REG_W),
    .IDX_W    (IDX_W),
    .LAST_IDX (NUM_REGS - 1)
) u_mwl_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .rd_ready_i (rd_ready_i),
    .rd_data_i  (rd_data_i),
    .rf_we_o    (rf_we_o),
    .rf_idx_o   (rf_idx_o),
    .rf_data_o  (rf_data_o),
    .done_o     (done_o)
);

// File: tb/tb_multi_word_loader.sv
module tb_multi_word_loader;

    localparam int NR = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [4:0]  first_reg_i = '0;
    logic [63:0] start_addr_i = '0;
    logic        rd_req_o;
    logic [63:0] rd_addr_o;
    logic        rd_ready_i = 1'b0;
    logic [31:0] rd_data_i = '0;
    logic        rf_we_o;
    logic [4:0]  rf_idx_o;
    logic [63:0] rf_data_o;
    logic        done_o;

    always #2 clk = ~clk;   // 250 MHz

    multi_word_loader dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .first_reg_i  (first_reg_i),
        .start_addr_i (start_addr_i),
        .rd_req_o     (rd_req_o),
        .rd_addr_o    (rd_addr_o),
        .rd_ready_i   (rd_ready_i),
        .rd_data_i    (rd_data_i),
        .rf_we_o      (rf_we_o),
        .rf_idx_o     (rf_idx_o),
        .rf_data_o    (rf_data_o),
        .done_o       (done_o)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [63:0] a);
        return a[31:0] ^ 32'h9C3B_5A71 ^ {a[7:0], a[31:8]};
    endfunction

    // reference model: phase 0 idle, 1 request, 2 write, 3 done
    int          m_ph = 0;
    int          m_idx = 0;
    logic [63:0] m_addr = '0;
    logic [63:0] acc_addr = '0;

    always @(posedge clk) begin
        if (!rst_n) m_ph = 0;
        else begin
            case (m_ph)
                0: if (start_i) begin
                    m_idx = int'(first_reg_i); m_addr = start_addr_i; m_ph = 1;
                end
                1: if (rd_ready_i) begin acc_addr = m_addr; m_ph = 2; end
                2: if (m_idx == NR - 1) m_ph = 3;
                   else begin m_idx++; m_addr = m_addr + 64'd4; m_ph = 1; end
                default: m_ph = 0;
            endcase
        end
    end

    // memory side stimulus
    int          ready_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    int          stall = 0;

    initial forever begin
        @(posedge clk); #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        rd_data_i = mem_word(acc_addr);
        case (ready_mode)
            0: rd_ready_i = 1'b1;
            1: rd_ready_i = lfsr[0];
            default: begin
                stall = (stall + 1) % 5;
                rd_ready_i = (stall == 0);
            end
        endcase
    end

    // per-cycle comparison against the model
    logic [63:0] shadow [NR];
    int          wcount = 0;

    always @(negedge clk) begin
        if (!rst_n || m_ph == 0 && $time < 40) begin
            chk(!rd_req_o && !rf_we_o && !done_o, "R1", "outputs idle in reset",
                {61'd0, rd_req_o, rf_we_o, done_o}, 64'd0);
        end else begin
            chk(rd_req_o === (m_ph == 1), "R3", "rd_req", 64'(rd_req_o), 64'(m_ph == 1));
            if (m_ph == 1)
                chk(rd_addr_o === m_addr, "R2,R5", "rd_addr", rd_addr_o, m_addr);
            chk(rf_we_o === (m_ph == 2), "R4", "rf_we", 64'(rf_we_o), 64'(m_ph == 2));
            if (m_ph == 2) begin
                chk(int'(rf_idx_o) == m_idx, "R6", "rf_idx", 64'(rf_idx_o), 64'(m_idx));
                chk(rf_data_o === {32'd0, rd_data_i}, "R4", "rf_data zero-extended",
                    rf_data_o, {32'd0, rd_data_i});
            end
            chk(done_o === (m_ph == 3), "R8", "done", 64'(done_o), 64'(m_ph == 3));
            chk(!(rd_req_o && rf_we_o), "R10", "req and write together",
                64'(rd_req_o && rf_we_o), 64'd0);
        end
        if (rf_we_o) begin
            shadow[rf_idx_o] = rf_data_o;
            wcount++;
        end
    end

    task automatic run_op(input int first, input logic [63:0] addr, input int mode,
                          input bit busy_start, input bit done_start);
        int cyc = 0;
        ready_mode = mode;
        for (int r = 0; r < NR; r++) shadow[r] = 64'hFFFF_FFFF_FFFF_FFFF;
        wcount = 0;
        @(posedge clk); #1;
        start_i = 1'b1; first_reg_i = 5'(first); start_addr_i = addr;
        @(posedge clk); #1;
        start_i = 1'b0;
        forever begin
            @(posedge clk); #1;
            cyc++;
            if (m_ph == 3) begin
                // R9: start presented in the DONE cycle must be ignored
                if (done_start) begin
                    start_i = 1'b1; first_reg_i = 5'd3; start_addr_i = 64'h77;
                    @(posedge clk); #1;
                end
                start_i = 1'b0;
                break;
            end
            // R9: start pulses while busy, with different operands
            if (busy_start && (cyc % 7 == 3)) begin
                start_i = 1'b1; first_reg_i = 5'd0; start_addr_i = 64'h5000;
            end else begin
                start_i = 1'b0;
            end
        end
        // R6, R7: number of writes
        chk(wcount == NR - first, (first == NR - 1) ? "R7" : "R6", "write count",
            64'(wcount), 64'(NR - first));
        // R4, R5, R6: register contents and untouched registers
        for (int r = 0; r < NR; r++) begin
            logic [63:0] exp;
            exp = (r >= first) ? {32'd0, mem_word(addr + 64'(4 * (r - first)))}
                               : 64'hFFFF_FFFF_FFFF_FFFF;
            chk(shadow[r] === exp, (r >= first) ? "R5" : "R6", "register image",
                shadow[r], exp);
        end
        // R9: nothing restarts afterwards
        repeat (4) begin
            @(negedge clk);
            chk(!rd_req_o && !rf_we_o, "R9", "idle after operation",
                64'(rd_req_o || rf_we_o), 64'd0);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        run_op(0,  64'h0000_0000_0000_1000, 0, 1'b0, 1'b0);
        run_op(20, 64'hFFFF_FFFF_FFFF_FFF0, 1, 1'b1, 1'b0);
        run_op(31, 64'h0000_0000_0000_0040, 2, 1'b0, 1'b1);   // R7
        run_op(5,  64'h8000_0000_0000_0ABC, 2, 1'b1, 1'b1);
        run_op(30, 64'h0000_0000_DEAD_BEE0, 1, 1'b0, 1'b0);
        if (!finished) begin
            finished = 1;
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL R6 watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule